// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing

This block is a first-in first-out buffer with separate write and read clocks. The two clocks may be unrelated or may be the same clock. Words are written on the write clock when the write enable is high and the buffer has room. They are read on the read clock. Write and read positions cross between the two clock domains as Gray-coded pointers, each through a two-stage synchroniser. Each status flag is therefore produced from registers in its own clock domain.

A timing mode is sampled from `fwftSel` while master reset is held. In standard timing, `fullIrN` is an active-low full flag and `emptyOrN` is an active-low empty flag. A read strobe is needed to move a word into the output register. In fall-through timing, `fullIrN` is high when no room is left and low when a word can be accepted. `emptyOrN` is low while a valid word is waiting on `rdData`. The output register is loaded from storage with no read request, and it counts as one extra storage slot. `halfN` goes low when more than half of the array is occupied. A partial reset empties the buffer but keeps the mode that was sampled at master reset.

Top module: `dual_clock_fifo`

## Requirements
- R1: In standard timing (`fwftSel`=0 at master reset), with no reads after reset, `fullIrN` goes low after exactly DEPTH accepted writes. Writes while it is low are dropped and are never read out.
- R2: In fall-through timing (`fwftSel`=1 at master reset), with no reads after reset, `fullIrN` goes high once DEPTH+1 words have been accepted, provided the first word has had time to reach the output register. Writes while it is high are dropped.
- R3: In fall-through timing, the first word written into an empty buffer appears on `rdData` with no read request. `emptyOrN` goes low on the same read-clock edge that loads it.
- R4: In fall-through timing, `emptyOrN` goes high on the read edge that consumes the last word. While it is high, `rdEn` has no effect: `rdData` holds and the next written word is the next one delivered.
- R5: In standard timing, `emptyOrN` is low while the buffer is empty. `rdData` changes only on a read taken while `emptyOrN` is high. Reads while it is low leave `rdData` and the read position unchanged.
- R6: Words are delivered in write order, with no loss or duplication, in both timings, with unrelated clock periods and irregular read patterns.
- R7: With the clocks tied together, a word written into an empty buffer on edge 0 raises the standard empty flag after edge 3. In fall-through timing the same write lowers `emptyOrN` after edge 4, exactly one read cycle later.
- R8: Partial reset empties the buffer and keeps the timing mode sampled at master reset, even if `fwftSel` has changed since.
- R9: Master reset samples `fwftSel` and clears `rdData` to zero. After it, standard timing shows `fullIrN`=1, `emptyOrN`=0, `halfN`=1, and fall-through timing shows `fullIrN`=0, `emptyOrN`=1.
- R10: `halfN` is low exactly when the write-domain count is greater than DEPTH/2. That count is the write position minus the synchronised read position, so a word already moved to the output register is not included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| masterRst | input | 1 | Active-high master reset; samples the timing mode |
| partRst | input | 1 | Active-high partial reset; empties the buffer and keeps the mode |
| fwftSel | input | 1 | Timing select sampled at master reset: 0 standard, 1 fall-through |
| wrEn | input | 1 | Write enable, sampled on wClk |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read enable, sampled on rClk |
| rdData | output | DATA_W | Output register |
| fullIrN | output | 1 | Standard: low when full. Fall-through: low when a word can be accepted |
| emptyOrN | output | 1 | Standard: low when empty. Fall-through: low when `rdData` holds a valid word |
| halfN | output | 1 | Low when more than DEPTH/2 words are in the array |

## Verification
The bench builds the block with ADDR_W=3 (DEPTH of 8) and an 18-bit data path. The small depth lets both the DEPTH and DEPTH+1 fill limits and the half-full threshold be reached in a few dozen writes. The read clock runs at 37 ns against the 20 ns write clock, so pointer crossings land at shifting phases during streaming. A tied-clock setting makes the edge counts of first-word latency exact and comparable between the two timings.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes from the write-side control to the storage array.
  typedef struct packed {
    logic push;
  } wrStrobe_t;

  // Strobes from the read-side control to the output register.
  typedef struct packed {
    logic load;
    logic clear;
  } rdStrobe_t;

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcfifo_wctl.sv
module dcfifo_wctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              masterRst,
  input  logic              anyRst,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [ADDR_W:0]   rGraySync,
  output logic [ADDR_W:0]   wGray,
  output logic [ADDR_W-1:0] wAddr,
  output wrStrobe_t         wStb,
  output logic              fullIrN,
  output logic              halfN
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  logic             fwftW;
  logic             wFull;
  logic [PTR_W-1:0] wBin, wBinNext, wGrayNext, rBinSync, wordCount;
  logic             push;

  assign push      = wrEn & ~wFull;
  assign wBinNext  = wBin + PTR_W'(push);
  assign wGrayNext = wBinNext ^ (wBinNext >> 1);

  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      rBinSync[i] = ^(rGraySync >> i);
    end
  end

  assign wordCount = wBin - rBinSync;

  always_ff @(posedge wClk) begin
    if (masterRst) fwftW <= fwftSel;
  end

  always_ff @(posedge wClk) begin
    if (anyRst) begin
      wBin  <= '0;
      wGray <= '0;
      wFull <= 1'b0;
    end else begin
      wBin  <= wBinNext;
      wGray <= wGrayNext;
      wFull <= (wGrayNext == {~rGraySync[PTR_W-1:PTR_W-2], rGraySync[PTR_W-3:0]});
    end
  end

  assign wAddr     = wBin[ADDR_W-1:0];
  assign wStb.push = push;
  assign fullIrN   = fwftW ? wFull : ~wFull;
  assign halfN     = ~(wordCount > PTR_W'(HALF));

  // Stored words seen from the write side never exceed the array size.
  p_count_bound_r1: assert property (@(posedge wClk) disable iff (anyRst)
    wordCount <= PTR_W'(DEPTH));

  // The pointer sent across domains changes by at most one bit per edge.
  p_gray_step_r6: assert property (@(posedge wClk) disable iff (anyRst)
    $countones(wGray ^ $past(wGray)) <= 1);

  // The timing mode moves only under master reset.
  p_mode_kept_r8: assert property (@(posedge wClk) disable iff (masterRst)
    1'b1 |=> $stable(fwftW));

endmodule

// File: rtl/dcfifo_rctl.sv
module dcfifo_rctl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              rClk,
  input  logic              masterRst,
  input  logic              anyRst,
  input  logic              fwftSel,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   wGraySync,
  output logic [ADDR_W:0]   rGray,
  output logic [ADDR_W-1:0] rAddr,
  output rdStrobe_t         rStb,
  output logic              fwftMode,
  output logic              emptyOrN
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic             rEmpty;
  logic             outValid;
  logic             pop;
  logic [PTR_W-1:0] rBin, rBinNext, rGrayNext, wBinSync;

  // Standard timing pops on request; fall-through pops to refill the output.
  always_comb begin
    if (fwftMode) pop = ~rEmpty & (~outValid | rdEn);
    else          pop = ~rEmpty & rdEn;
  end

  assign rBinNext  = rBin + PTR_W'(pop);
  assign rGrayNext = rBinNext ^ (rBinNext >> 1);

  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      wBinSync[i] = ^(wGraySync >> i);
    end
  end

  always_ff @(posedge rClk) begin
    if (masterRst) fwftMode <= fwftSel;
  end

  always_ff @(posedge rClk) begin
    if (anyRst) begin
      rBin     <= '0;
      rGray    <= '0;
      rEmpty   <= 1'b1;
      outValid <= 1'b0;
    end else begin
      rBin   <= rBinNext;
      rGray  <= rGrayNext;
      rEmpty <= (rGrayNext == wGraySync);
      if (fwftMode) begin
        if (pop)       outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  assign rAddr      = rBin[ADDR_W-1:0];
  assign rStb.load  = pop;
  assign rStb.clear = anyRst;
  assign emptyOrN   = fwftMode ? ~outValid : ~rEmpty;

  // The read position never passes the synchronised write position.
  p_no_underflow_r5: assert property (@(posedge rClk) disable iff (anyRst)
    (wBinSync - rBin) <= PTR_W'(DEPTH));

  // A valid fall-through word stays valid until a read consumes it.
  p_or_hold_r4: assert property (@(posedge rClk) disable iff (anyRst)
    (fwftMode && outValid && !rdEn) |=> outValid);

  // With nothing stored and nothing shown, output-ready cannot appear.
  p_or_idle_r4: assert property (@(posedge rClk) disable iff (anyRst)
    (fwftMode && !outValid && rEmpty) |=> !outValid);

endmodule

// File: rtl/dcfifo_store.sv
module dcfifo_store
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  wrStrobe_t         wStb,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  rdStrobe_t         rStb,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wClk) begin
    if (wStb.push) mem[wAddr] <= wData;
  end

  always_ff @(posedge rClk) begin
    if (rStb.clear)     dataOut <= '0;
    else if (rStb.load) dataOut <= mem[rAddr];
  end

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              masterRst,
  input  logic              partRst,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fullIrN,
  output logic              emptyOrN,
  output logic              halfN
);

  localparam int PTR_W = ADDR_W + 1;

  logic              anyRst;
  logic              fwftMode;
  logic [PTR_W-1:0]  wGray, rGray, wGraySync, rGraySync;
  logic [ADDR_W-1:0] wAddr, rAddr;
  wrStrobe_t         wStb;
  rdStrobe_t         rStb;

  assign anyRst = masterRst | partRst;

  dcfifo_sync #(.W(PTR_W)) u_r2w (
    .clk(wClk), .rst(anyRst), .d(rGray), .q(rGraySync)
  );

  dcfifo_sync #(.W(PTR_W)) u_w2r (
    .clk(rClk), .rst(anyRst), .d(wGray), .q(wGraySync)
  );

  dcfifo_wctl #(.ADDR_W(ADDR_W)) u_wctl (
    .wClk(wClk), .masterRst(masterRst), .anyRst(anyRst), .fwftSel(fwftSel),
    .wrEn(wrEn), .rGraySync(rGraySync), .wGray(wGray), .wAddr(wAddr),
    .wStb(wStb), .fullIrN(fullIrN), .halfN(halfN)
  );

  dcfifo_rctl #(.ADDR_W(ADDR_W)) u_rctl (
    .rClk(rClk), .masterRst(masterRst), .anyRst(anyRst), .fwftSel(fwftSel),
    .rdEn(rdEn), .wGraySync(wGraySync), .rGray(rGray), .rAddr(rAddr),
    .rStb(rStb), .fwftMode(fwftMode), .emptyOrN(emptyOrN)
  );

  dcfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wClk(wClk), .rClk(rClk), .wStb(wStb), .wAddr(wAddr), .wData(wrData),
    .rStb(rStb), .rAddr(rAddr), .dataOut(rdData)
  );

  // Standard timing: the output moves only on a read taken while not empty.
  p_std_hold_r5: assert property (@(posedge rClk) disable iff (anyRst)
    (!fwftMode && !(rdEn && emptyOrN)) |=> $stable(rdData));

endmodule

// File: tb/sim_dual_clock_fifo.sv
`timescale 1ns/1ps
module sim_dual_clock_fifo;

  localparam int DW    = 18;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic          wClk = 0, rClkFree = 0, tied = 0;
  logic          rClk;
  logic          masterRst = 1, partRst = 0, fwftSel = 0;
  logic          wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          fullIrN, emptyOrN, halfN;

  always #10   wClk = ~wClk;
  always #18.5 rClkFree = ~rClkFree;
  assign rClk = tied ? wClk : rClkFree;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wClk(wClk), .rClk(rClk), .masterRst(masterRst), .partRst(partRst),
    .fwftSel(fwftSel), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .fullIrN(fullIrN), .emptyOrN(emptyOrN), .halfN(halfN)
  );

  int nChecks = 0, nFail = 0, nAcc = 0;
  logic fwft = 0, readOn = 0, done = 0;
  logic [DW-1:0] q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareFront(input string tag);
    logic [DW-1:0] exp;
    if (q.size() == 0) check(0, {tag, " unexpected word"}, 32'(rdData), 32'hFFFFFFFF);
    else begin
      exp = q.pop_front();
      check(rdData == exp, tag, 32'(rdData), 32'(exp));
    end
  endtask

  // Monitor: consumes words as the design presents them.
  initial begin
    logic pending = 0, wasOn = 0;
    logic [7:0] lfsr = 8'h5A;
    forever begin
      @(negedge rClk);
      if (pending) begin
        pending = 0;
        compareFront("R6 order");
      end
      if (readOn) begin
        rdEn = 0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (lfsr[0] | lfsr[1]) begin
          if (!fwft && emptyOrN) begin
            rdEn = 1; pending = 1;
          end else if (fwft && !emptyOrN) begin
            compareFront("R6 order");
            rdEn = 1;
          end
        end
      end else if (wasOn) rdEn = 0;
      wasOn = readOn;
    end
  end

  task automatic doMasterReset(input logic mode, input logic tie);
    readOn = 0;
    repeat (3) @(negedge wClk);
    masterRst = 1; fwftSel = mode; wrEn = 0; rdEn = 0;
    tied = tie;
    repeat (6) @(negedge rClkFree);
    q.delete(); fwft = mode; nAcc = 0;
    @(negedge wClk);
    masterRst = 0;
    repeat (4) @(negedge wClk);
  endtask

  task automatic doPartialReset(input logic newSel);
    readOn = 0;
    repeat (3) @(negedge wClk);
    partRst = 1; fwftSel = newSel; wrEn = 0; rdEn = 0;
    repeat (6) @(negedge rClkFree);
    q.delete(); nAcc = 0;
    @(negedge wClk);
    partRst = 0;
    repeat (4) @(negedge wClk);
  endtask

  // Driver: a write is expected to land only if room was shown before the edge.
  task automatic writeWord(input logic [DW-1:0] d);
    logic acc;
    @(negedge wClk);
    acc = fwft ? !fullIrN : fullIrN;
    wrEn = 1; wrData = d;
    if (acc) begin q.push_back(d); nAcc++; end
    @(negedge wClk);
    wrEn = 0;
  endtask

  task automatic drain(input string tag);
    readOn = 1;
    for (int i = 0; i < 3000 && q.size() > 0; i++) @(negedge rClk);
    repeat (12) @(negedge rClk);
    readOn = 0;
    repeat (3) @(negedge rClk);
    check(q.size() == 0, {tag, " all delivered"}, 32'(q.size()), 0);
    check(emptyOrN == (fwft ? 1'b1 : 1'b0), {tag, " empty after drain"}, 32'(emptyOrN), 32'(fwft));
  endtask

  task automatic manualRead();
    @(negedge rClk); rdEn = 1;
    @(negedge rClk); rdEn = 0;
  endtask

  task automatic latency(input logic mode, output int n);
    @(negedge wClk);
    wrEn = 1; wrData = 18'h155; q.push_back(18'h155);
    @(posedge wClk);
    @(negedge wClk);
    wrEn = 0;
    n = 0;
    while ((mode ? emptyOrN : !emptyOrN) && n < 12) begin
      @(posedge wClk); n++;
      @(negedge wClk);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [DW-1:0] held;

    // R9 reset state, standard timing
    doMasterReset(0, 0);
    check(fullIrN == 1, "R9 std fullIrN", 32'(fullIrN), 1);
    check(emptyOrN == 0, "R9 std emptyOrN", 32'(emptyOrN), 0);
    check(halfN == 1, "R9 std halfN", 32'(halfN), 1);
    check(rdData == 0, "R9 rdData cleared", 32'(rdData), 0);

    // R1 fill with no reads, R10 half threshold
    for (int i = 1; i <= DEPTH + 2; i++) begin
      writeWord(DW'(i * 37 + 3));
      if (i == DEPTH / 2) check(halfN == 1, "R10 at half", 32'(halfN), 1);
      if (i == DEPTH / 2 + 1) check(halfN == 0, "R10 above half", 32'(halfN), 0);
    end
    check(nAcc == DEPTH, "R1 accepted count", 32'(nAcc), 32'(DEPTH));
    check(fullIrN == 0, "R1 full flag", 32'(fullIrN), 0);
    drain("R1");

    // R5 standard needs a read; reads when empty are ignored
    doMasterReset(0, 0);
    writeWord(18'h1234);
    repeat (8) @(negedge rClk);
    check(emptyOrN == 1, "R5 not empty", 32'(emptyOrN), 1);
    check(rdData == 0, "R5 no read no data", 32'(rdData), 0);
    manualRead();
    check(rdData == 18'h1234, "R5 read data", 32'(rdData), 32'h1234);
    repeat (2) @(negedge rClk);
    check(emptyOrN == 0, "R5 empty again", 32'(emptyOrN), 0);
    manualRead(); manualRead();
    check(rdData == 18'h1234, "R5 read on empty ignored", 32'(rdData), 32'h1234);
    writeWord(18'h2BCD);
    repeat (8) @(negedge rClk);
    manualRead();
    check(rdData == 18'h2BCD, "R5 next word", 32'(rdData), 32'h2BCD);

    // R6 streaming, standard timing, unrelated clocks
    doMasterReset(0, 0);
    readOn = 1;
    for (int i = 0; i < 60; i++) writeWord(DW'(i * 1103 + 17));
    drain("R6 std");

    // R9 reset state, fall-through
    doMasterReset(1, 0);
    check(fullIrN == 0, "R9 fwft fullIrN", 32'(fullIrN), 0);
    check(emptyOrN == 1, "R9 fwft emptyOrN", 32'(emptyOrN), 1);

    // R3 first word falls through, R2 capacity DEPTH+1
    writeWord(18'h0A5A5);
    repeat (12) @(negedge rClk);
    check(emptyOrN == 0, "R3 output ready", 32'(emptyOrN), 0);
    check(rdData == 18'h0A5A5, "R3 fall-through data", 32'(rdData), 32'h0A5A5);
    repeat (4) @(negedge wClk);
    for (int i = 0; i < DEPTH + 2; i++) writeWord(DW'(i * 91 + 1));
    check(nAcc == DEPTH + 1, "R2 accepted count", 32'(nAcc), 32'(DEPTH + 1));
    check(fullIrN == 1, "R2 input-ready high", 32'(fullIrN), 1);
    drain("R2");

    // R4 reads while output-ready is high are ignored
    held = rdData;
    manualRead(); manualRead(); manualRead();
    check(emptyOrN == 1, "R4 stays not ready", 32'(emptyOrN), 1);
    check(rdData == held, "R4 data held", 32'(rdData), 32'(held));
    writeWord(18'h2A5);
    repeat (12) @(negedge rClk);
    check(rdData == 18'h2A5, "R4 next word delivered", 32'(rdData), 32'h2A5);
    drain("R4");

    // R6 streaming, fall-through timing
    readOn = 1;
    for (int i = 0; i < 60; i++) writeWord(DW'(i * 2711 + 9));
    drain("R6 fwft");

    // R8 partial reset keeps fall-through even with select changed
    for (int i = 0; i < 3; i++) writeWord(DW'(i + 40));
    doPartialReset(0);
    check(emptyOrN == 1, "R8 emptied, mode kept", 32'(emptyOrN), 1);
    check(fullIrN == 0, "R8 input ready", 32'(fullIrN), 0);
    writeWord(18'h3C3C);
    repeat (12) @(negedge rClk);
    check(emptyOrN == 0 && rdData == 18'h3C3C, "R8 word falls through", 32'(rdData), 32'h3C3C);

    // R7 first-word latency with tied clocks
    doMasterReset(0, 1);
    latency(0, n);
    check(n == 3, "R7 standard latency", 32'(n), 3);
    doMasterReset(1, 1);
    latency(1, n);
    check(n == 4, "R7 fall-through latency", 32'(n), 4);
    check(rdData == 18'h155, "R7 word shown", 32'(rdData), 32'h155);
    readOn = 1;
    for (int i = 0; i < 30; i++) writeWord(DW'(i * 555 + 2));
    drain("R7 tied stream");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule